// File: doc/BRIEF.md
# Screen-engine coverage mask unit

This unit takes a screen-space primitive, given as three vertices in unsigned pixel coordinates, and reports which of four screen-engine backends its axis-aligned bounding rectangle touches. The screen is cut into square tiles of 32 pixels. Each tile belongs to one engine under an interleaved XOR mapping, so neighbouring tiles go to different engines. The result is a 4-bit mask. Bit n is set when engine n owns at least one tile inside the rectangle.

The datapath has two registered stages. The first stage forms the bounding box from the three vertices. The second stage decides whether the box spans three or more tile steps on either axis. If it does, every engine is covered, the full mask is reported and no tile walk is done. If it does not, the second stage walks the covered tiles, at most three by three. It uses only the two low bits of each corner's tile index, stepping modulo 4, and ORs in each tile's engine.

Both the input and the output use a valid/ready handshake, and each stage advances only when the stage after it can take the data. An upstream primitive-setup stage feeds the unit, and a distributor that forwards the primitive to the flagged engines consumes its output.

Top module: `tile_engine_cover`

## Requirements
- R1: The bounding box is the unsigned minimum and maximum of the three vertex x values and of the three vertex y values. Vertex order has no effect on the result.
- R2: The tile at column bits c = x[6:5] and row bits r = y[6:5] belongs to engine e, where e[1] = c[0] XOR r[1] and e[0] = r[0] XOR c[1].
- R3: If (x_max>>5) − (x_min>>5) ≥ 3 or (y_max>>5) − (y_min>>5) ≥ 3, then out_mask is 4'b1111 and out_full is 1.
- R4: Outside the R3 case, out_full is 0. out_mask is then the OR of the engine bits of every tile from the min column to the max column and from the min row to the max row, with the 2-bit indices wrapping modulo 4. This equals the set of engines owning any pixel of the rectangle.
- R5: A rectangle whose corner tile fields x_min[6:5], y_min[6:5], x_max[6:5] and y_max[6:5] are all zero, and which is not in the R3 case, yields out_mask 4'b0001.
- R6: out_mask bit n (n = 0..3) stands for engine n. A rectangle inside a single tile therefore sets exactly one bit, the bit at the position given by R2.
- R7: When out_ready is held high, a primitive accepted at a clock edge appears on the output after the next edge. in_ready stays high, so one primitive is accepted every cycle, and in_ready is high whenever out_valid is low.
- R8: While out_valid is high and out_ready is low, out_mask and out_full hold their values and out_valid stays high. Once both stages are full, in_ready is low. No primitive is lost or duplicated.
- R9: After a synchronous active-low reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Primitive on the vertex inputs is valid |
| in_ready | output | 1 | Unit accepts a primitive this cycle |
| vx0 | input | COORD_W | Vertex 0 x, unsigned pixels |
| vy0 | input | COORD_W | Vertex 0 y, unsigned pixels |
| vx1 | input | COORD_W | Vertex 1 x |
| vy1 | input | COORD_W | Vertex 1 y |
| vx2 | input | COORD_W | Vertex 2 x |
| vy2 | input | COORD_W | Vertex 2 y |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | 4 | Engine coverage mask, bit n = engine n |
| out_full | output | 1 | Large-extent shortcut was taken |

## Verification
The bench builds the unit with its default parameters: 16-bit coordinates and 32-pixel tiles. With these values the tile index runs well past the 2-bit field, so rectangles that cross a 128-pixel boundary reach the modulo-4 wrap of the walk, and vertices near 65535 check that the min/max is unsigned. Small random rectangles are compared against a model that visits every pixel, so the tile walk is checked against the true pixel ownership rather than against a second copy of the walk.

// File: rtl/tec_pkg.sv
// Package: shared constants, types and the tile-to-engine mapping.
// Assumes exactly four engines and a 2-bit tile field per axis.
package tec_pkg;
    localparam int unsigned NUM_ENG    = 4;
    localparam int unsigned SPAN_LIMIT = 3;   // tile steps that force a full mask
    localparam int unsigned WALK_MAX   = 3;   // tiles per axis in the walk

    typedef logic [NUM_ENG-1:0] eng_mask_t;

    // Engine owning a tile, from the column and row index fields.
    function automatic logic [1:0] engine_of(input logic [1:0] col, input logic [1:0] row);
        return {col[0] ^ row[1], row[0] ^ col[1]};
    endfunction
endpackage

// File: rtl/tec_bbox.sv
// Bounding box former: unsigned min/max over three vertices per axis.
// Purely combinational; the caller registers the result.
module tec_bbox #(
    parameter int unsigned COORD_W = 16
) (
    input  logic [COORD_W-1:0] vx0,
    input  logic [COORD_W-1:0] vy0,
    input  logic [COORD_W-1:0] vx1,
    input  logic [COORD_W-1:0] vy1,
    input  logic [COORD_W-1:0] vx2,
    input  logic [COORD_W-1:0] vy2,
    output logic [COORD_W-1:0] x_lo,
    output logic [COORD_W-1:0] x_hi,
    output logic [COORD_W-1:0] y_lo,
    output logic [COORD_W-1:0] y_hi
);
    logic [COORD_W-1:0] xs [3];
    logic [COORD_W-1:0] ys [3];

    // Gather the vertices per axis so one reduction loop serves both.
    always_comb begin
        xs[0] = vx0; xs[1] = vx1; xs[2] = vx2;
        ys[0] = vy0; ys[1] = vy1; ys[2] = vy2;
    end

    // Unsigned min/max reduction over the three vertices.
    always_comb begin
        x_lo = xs[0]; x_hi = xs[0];
        y_lo = ys[0]; y_hi = ys[0];
        for (int k = 1; k < 3; k++) begin
            if (xs[k] < x_lo) x_lo = xs[k];
            if (xs[k] > x_hi) x_hi = xs[k];
            if (ys[k] < y_lo) y_lo = ys[k];
            if (ys[k] > y_hi) y_hi = ys[k];
        end
    end
endmodule

// File: rtl/tec_mask.sv
// Mask former: large-extent shortcut plus a modulo-4 walk over tile fields.
// Assumes x_lo <= x_hi and y_lo <= y_hi. Combinational.
module tec_mask
    import tec_pkg::*;
#(
    parameter int unsigned COORD_W   = 16,
    parameter int unsigned TILE_LOG2 = 5
) (
    input  logic [COORD_W-1:0] x_lo,
    input  logic [COORD_W-1:0] x_hi,
    input  logic [COORD_W-1:0] y_lo,
    input  logic [COORD_W-1:0] y_hi,
    output eng_mask_t          mask,
    output logic               full
);
    localparam int unsigned TIDX_W = COORD_W - TILE_LOG2;

    logic [TIDX_W-1:0] tx_lo, tx_hi, ty_lo, ty_hi;
    logic [1:0]        cf_lo, cf_hi, rf_lo, rf_hi;
    logic [1:0]        col_span, row_span;
    eng_mask_t         walk;

    // Tile indices and their 2-bit fields.
    always_comb begin
        tx_lo = x_lo[COORD_W-1:TILE_LOG2];
        tx_hi = x_hi[COORD_W-1:TILE_LOG2];
        ty_lo = y_lo[COORD_W-1:TILE_LOG2];
        ty_hi = y_hi[COORD_W-1:TILE_LOG2];
        cf_lo = x_lo[TILE_LOG2+1:TILE_LOG2];
        cf_hi = x_hi[TILE_LOG2+1:TILE_LOG2];
        rf_lo = y_lo[TILE_LOG2+1:TILE_LOG2];
        rf_hi = y_hi[TILE_LOG2+1:TILE_LOG2];
        col_span = cf_hi - cf_lo;
        row_span = rf_hi - rf_lo;
    end

    // Shortcut when either axis spans SPAN_LIMIT or more tile steps.
    always_comb begin
        full = ((tx_hi - tx_lo) >= TIDX_W'(SPAN_LIMIT)) ||
               ((ty_hi - ty_lo) >= TIDX_W'(SPAN_LIMIT));
    end

    // Wrapping walk over at most WALK_MAX x WALK_MAX tiles.
    always_comb begin
        walk = '0;
        for (int i = 0; i < WALK_MAX; i++) begin
            for (int j = 0; j < WALK_MAX; j++) begin
                if (2'(i) <= col_span && 2'(j) <= row_span)
                    walk[engine_of(cf_lo + 2'(i), rf_lo + 2'(j))] = 1'b1;
            end
        end
    end

    // Final selection between shortcut and walk.
    always_comb mask = full ? '1 : walk;
endmodule

// File: rtl/tile_engine_cover.sv
// Top: two-stage pipeline (bounding box, then mask) with valid/ready at
// both edges. Each stage loads when the stage after it can accept data.
module tile_engine_cover
    import tec_pkg::*;
#(
    parameter int unsigned COORD_W   = 16,
    parameter int unsigned TILE_LOG2 = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [COORD_W-1:0] vx0,
    input  logic [COORD_W-1:0] vy0,
    input  logic [COORD_W-1:0] vx1,
    input  logic [COORD_W-1:0] vy1,
    input  logic [COORD_W-1:0] vx2,
    input  logic [COORD_W-1:0] vy2,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [3:0]         out_mask,
    output logic               out_full
);
    logic [COORD_W-1:0] bx_lo, bx_hi, by_lo, by_hi;
    logic [COORD_W-1:0] s1_x_lo, s1_x_hi, s1_y_lo, s1_y_hi;
    logic               s1_valid, s2_take, s1_take;
    eng_mask_t          m_mask;
    logic               m_full;

    tec_bbox #(.COORD_W(COORD_W)) u_bbox (
        .vx0(vx0), .vy0(vy0), .vx1(vx1), .vy1(vy1), .vx2(vx2), .vy2(vy2),
        .x_lo(bx_lo), .x_hi(bx_hi), .y_lo(by_lo), .y_hi(by_hi)
    );

    // Handshake: a stage may load when it is empty or is being drained.
    always_comb begin
        s2_take  = !out_valid || out_ready;
        in_ready = !s1_valid || s2_take;
        s1_take  = in_valid && in_ready;
    end

    // Stage 1 register: bounding box and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else if (in_ready) begin
            s1_valid <= in_valid;
        end
    end

    // Stage 1 data, loaded only on an accepted primitive.
    always_ff @(posedge clk) begin
        if (s1_take) begin
            s1_x_lo <= bx_lo;
            s1_x_hi <= bx_hi;
            s1_y_lo <= by_lo;
            s1_y_hi <= by_hi;
        end
    end

    tec_mask #(.COORD_W(COORD_W), .TILE_LOG2(TILE_LOG2)) u_mask (
        .x_lo(s1_x_lo), .x_hi(s1_x_hi), .y_lo(s1_y_lo), .y_hi(s1_y_hi),
        .mask(m_mask), .full(m_full)
    );

    // Stage 2 register: output valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (s2_take) begin
            out_valid <= s1_valid;
        end
    end

    // Stage 2 data: mask and shortcut flag.
    always_ff @(posedge clk) begin
        if (s2_take && s1_valid) begin
            out_mask <= m_mask;
            out_full <= m_full;
        end
    end
endmodule

// File: rtl/tec_checker.sv
// Checker for tile_engine_cover: handshake and mask invariants at the ports.
module tec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [3:0] out_mask,
    input logic       out_full
);
    // R3: the shortcut flag always comes with every engine set.
    a_r3_full_all_engines: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_full) |-> (out_mask == 4'hF));

    // R4: any non-degenerate rectangle touches at least one engine.
    a_r4_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask != 4'h0));

    // R8: a stalled result keeps its valid bit.
    a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    // R8: a stalled result keeps its data.
    a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_mask) && $stable(out_full)));

    // R7: an empty output stage never blocks the input.
    a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
endmodule

bind tile_engine_cover tec_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_mask(out_mask), .out_full(out_full)
);

// File: tb/tile_engine_cover_tb.sv
// Directed bench for tile_engine_cover; one task per scenario.
module tile_engine_cover_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] vx0 = '0, vy0 = '0, vx1 = '0, vy1 = '0, vx2 = '0, vy2 = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_mask;
    logic        out_full;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tile_engine_cover u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .vx0(vx0), .vy0(vy0), .vx1(vx1), .vy1(vy1), .vx2(vx2), .vy2(vy2),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_mask(out_mask), .out_full(out_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Engine of a pixel, per R2.
    function automatic logic [1:0] pix_eng(input int x, input int y);
        logic [15:0] xx, yy;
        xx = 16'(x); yy = 16'(y);
        return {xx[5] ^ yy[6], yy[5] ^ xx[6]};
    endfunction

    // Reference: R3 shortcut, else OR over every pixel.
    task automatic ref_mask(input int xl, input int xh, input int yl, input int yh,
                            output logic [3:0] m, output logic f);
        f = ((xh >> 5) - (xl >> 5) >= 3) || ((yh >> 5) - (yl >> 5) >= 3);
        m = 4'h0;
        if (f) m = 4'hF;
        else
            for (int x = xl; x <= xh; x++)
                for (int y = yl; y <= yh; y++)
                    m[pix_eng(x, y)] = 1'b1;
    endtask

    task automatic set_in(input int a, input int b, input int c, input int d,
                          input int e, input int g);
        vx0 = 16'(a); vy0 = 16'(b); vx1 = 16'(c); vy1 = 16'(d); vx2 = 16'(e); vy2 = 16'(g);
    endtask

    // One primitive through an empty pipe, checking latency and result.
    task automatic run_one(input int a, input int b, input int c, input int d,
                           input int e, input int g, input logic [3:0] em,
                           input logic ef, input string req);
        @(negedge clk);
        out_ready = 1'b0;
        set_in(a, b, c, d, e, g);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " R7 latency valid"}, 32'(out_valid), 32'd1);
        chk({req, " mask"}, 32'(out_mask), 32'(em));
        chk({req, " full"}, 32'(out_full), 32'(ef));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R9 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R9 in_ready after reset", 32'(in_ready), 32'd1);
    endtask

    task automatic test_zero_fields();
        // All corner fields zero: two tiles inside columns/rows 0 and 4 (wrap to 0) excluded; keep in tile 0.
        run_one(3, 7, 30, 2, 15, 31, 4'b0001, 1'b0, "R5 zero fields");
        // Fields zero but tile index 4 (x 128..159): still engine 0.
        run_one(130, 260, 150, 270, 140, 265, 4'b0001, 1'b0, "R5 zero fields high tile");
    endtask

    task automatic test_single_tiles();
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                logic [3:0] em;
                logic [1:0] e;
                e  = {c[0] ^ r[1], r[0] ^ c[1]};
                em = 4'b0001 << e;
                run_one(c*32+4, r*32+9, c*32+20, r*32+1, c*32+11, r*32+28, em, 1'b0,
                        "R2 R6 single tile");
            end
    endtask

    task automatic test_bbox_order();
        logic [3:0] m; logic f;
        ref_mask(65480, 65535, 65440, 65500, m, f);
        run_one(65535, 65440, 65480, 65500, 65500, 65470, m, f, "R1 order a high coords");
        run_one(65500, 65470, 65535, 65440, 65480, 65500, m, f, "R1 order b high coords");
        run_one(65480, 65500, 65500, 65470, 65535, 65440, m, f, "R1 order c high coords");
    endtask

    task automatic test_shortcut();
        run_one(0, 0, 96, 5, 10, 3, 4'hF, 1'b1, "R3 x span 3");
        run_one(7, 500, 9, 700, 8, 600, 4'hF, 1'b1, "R3 y span large");
        // Span exactly 2 tile steps: walk, not shortcut.
        run_one(31, 0, 64, 0, 40, 0, 4'b0111, 1'b0, "R3 span 2 boundary");
    endtask

    task automatic test_random_walk();
        for (int n = 0; n < 40; n++) begin
            int xl, yl, xh, yh, xm, ym;
            logic [3:0] m; logic f;
            xl = int'($urandom_range(0, 65000));
            yl = int'($urandom_range(0, 65000));
            xh = xl + int'($urandom_range(0, 95));
            yh = yl + int'($urandom_range(0, 95));
            xm = (xl + xh) / 2; ym = (yl + yh) / 2;
            ref_mask(xl, xh, yl, yh, m, f);
            run_one(xl, ym, xm, yl, xh, yh, m, f, "R4 random walk");
        end
        // Wrap across a 128-pixel boundary: columns 3,0 rows 3,0.
        begin
            logic [3:0] m; logic f;
            ref_mask(100, 140, 100, 140, m, f);
            run_one(100, 100, 140, 140, 120, 120, m, f, "R4 wrap");
        end
    endtask

    task automatic test_stream();
        localparam int N = 8;
        logic [3:0] em [N];
        logic       ef [N];
        for (int i = 0; i < N; i++) ref_mask(i*40, i*40+20, i*20, i*20+50, em[i], ef[i]);
        @(negedge clk);
        out_ready = 1'b1;
        for (int c = 0; c < N + 2; c++) begin
            if (c >= 2) begin
                chk("R7 stream valid", 32'(out_valid), 32'd1);
                chk("R7 stream mask", 32'(out_mask), 32'(em[c-2]));
                chk("R7 stream full", 32'(out_full), 32'(ef[c-2]));
            end
            if (c < N) begin
                set_in(c*40, c*20, c*40+20, c*20+50, c*40+10, c*20+25);
                in_valid = 1'b1;
                chk("R7 stream in_ready", 32'(in_ready), 32'd1);
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk("R7 stream drained", 32'(out_valid), 32'd0);
        out_ready = 1'b0;
    endtask

    task automatic test_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        set_in(1, 1, 2, 2, 3, 3); in_valid = 1'b1;             // A -> 0001
        @(negedge clk);
        set_in(40, 5, 50, 10, 45, 20);                          // B -> 0100
        @(negedge clk);
        set_in(0, 0, 200, 0, 100, 0);                           // C -> full
        for (int k = 0; k < 3; k++) begin
            chk("R8 in_ready low when full", 32'(in_ready), 32'd0);
            chk("R8 held mask A", 32'(out_mask), 32'h1);
            chk("R8 held valid", 32'(out_valid), 32'd1);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 second item B", 32'(out_mask), 32'h4);
        chk("R8 second valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        chk("R8 third item C", 32'(out_mask), 32'hF);
        chk("R8 third full", 32'(out_full), 32'd1);
        @(negedge clk);
        chk("R8 no duplicate", 32'(out_valid), 32'd0);
        out_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_zero_fields();
        test_single_tiles();
        test_bbox_order();
        test_shortcut();
        test_random_walk();
        test_stream();
        test_backpressure();
        finish_run();
    end
endmodule